// File: doc/BRIEF.md
# Time-Stamped Pin Event Engine

This block drives or observes one pin against an absolute 64-bit time value supplied from outside. When the pin is an output, software programs a 64-bit match time. Once the time input reaches or passes that value, the pin toggles. With repeat mode selected, the match time then moves forward by a programmed 64-bit step, so the pin produces a square wave locked to the timebase. When the pin is an input, each edge of the selected kind records the current time and the updated event tally.

Software reaches the block through 32-bit registers with single-cycle read and write strobes. Read data appears on the cycle after the strobe and holds until the next read. Each 64-bit quantity is split into two words. Reading the low word of a time-like register copies its high word into a shared holding register, and reading the high word returns that held copy. Several pins are built by placing several copies of the block, each at its own window in the address space.

The mode state machine has four states. IDLE is entered at reset and whenever the enable bit is clear. While in IDLE, the working match time follows the programmed one. IDLE goes to ARMED when the block is enabled as an output, or to LISTEN when it is enabled as an input. In ARMED, the pin toggles once the time is due. If repeat mode is set, ARMED stays in ARMED and advances the working match time by one step. If repeat mode is clear, ARMED goes to SPENT. SPENT, ARMED and LISTEN all return to IDLE when enable is cleared.

Top module: `timed_pin_engine`

## Requirements
- R1: After reset the pin output is 0, and the control, match, step, capture and tally registers all read 0.
- R2: The control word at offset 0x10 holds enable in bit 0, input direction in bit 1, edge select in bits 3:2 and repeat mode in bit 4. Higher bits are discarded. Read data is valid on the cycle after the read strobe.
- R3: Writes to the match words (0x20 low, 0x24 high) and the step words (0x28 low, 0x2C high) take effect only while enable is 0. While enable is 1 they are ignored.
- R4: As an enabled output without repeat mode, the pin toggles exactly once when the time is greater than or equal to the match value. After that it holds, even as time advances further.
- R5: As an enabled output with repeat mode, each toggle moves the working match time forward by the step. If time is already several steps ahead, the block makes one toggle per clock until it catches up.
- R6: While enable is 0 the pin output never changes. Setting enable again re-arms from the programmed match value.
- R7: Edge select 00 qualifies only rising input edges.
- R8: Edge select 01 qualifies only falling input edges.
- R9: Edge select 10 (and 11) qualifies both rising and falling input edges.
- R10: On each qualifying edge, the tally (0x40/0x44) rises by one. The time at that clock is stored in the capture (0x30/0x34), and the new tally value is stored in the tally capture (0x38/0x3C).
- R11: Input edges are ignored while the block is disabled or in output mode. A pin that is already high when the input mode is enabled is not counted as an edge.
- R12: Reading a low word (0x00 time, 0x30, 0x38, 0x40) captures its high word. A following read of the matching high word returns that captured value even if the source has since changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Free-running time value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| pin_in | input | 1 | Asynchronous pin input |
| pin_out | output | 1 | Pin output |

## Verification
The hardest case to reach is repeat-mode catch-up, where time already stands several steps past the working match value. The bench gets there by disabling the block, jumping the time input straight past the next match by two whole steps, and then holding time still. It then counts the resulting back-to-back toggles by their final parity. Input captures are made exact in the same way: the time input is changed in the same cycle as each pin change, so the stamped value is known regardless of the synchroniser delay.

// File: rtl/tpe_pkg.sv
package tpe_pkg;

    localparam int CTRL_W = 5;

    // register offsets within one pin's window
    localparam logic [7:0] OFS_CLOCK_LO  = 8'h00;
    localparam logic [7:0] OFS_CLOCK_HI  = 8'h04;
    localparam logic [7:0] OFS_CFG       = 8'h10;
    localparam logic [7:0] OFS_MATCH_LO  = 8'h20;
    localparam logic [7:0] OFS_MATCH_HI  = 8'h24;
    localparam logic [7:0] OFS_STEP_LO   = 8'h28;
    localparam logic [7:0] OFS_STEP_HI   = 8'h2C;
    localparam logic [7:0] OFS_STAMP_LO  = 8'h30;
    localparam logic [7:0] OFS_STAMP_HI  = 8'h34;
    localparam logic [7:0] OFS_KEPT_LO   = 8'h38;
    localparam logic [7:0] OFS_KEPT_HI   = 8'h3C;
    localparam logic [7:0] OFS_TALLY_LO  = 8'h40;
    localparam logic [7:0] OFS_TALLY_HI  = 8'h44;

    localparam logic [1:0] EDGE_RISE = 2'b00;
    localparam logic [1:0] EDGE_FALL = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SPENT,
        ST_LISTEN
    } tpe_state_e;

    // packed so that enable lands on bit 0 and repeat on bit 4
    typedef struct packed {
        logic       repeat_on;
        logic [1:0] edge_sel;
        logic       dir_in;
        logic       en;
    } tpe_ctrl_t;

endpackage

// File: rtl/tpe_edge_sense.sv
module tpe_edge_sense
    import tpe_pkg::*;
#(
    parameter int SYNC_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_raw,
    input  logic       arm,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    // chain[SYNC_LEN-1] is the settled level, chain[SYNC_LEN] its previous value
    logic [SYNC_LEN:0] chain;
    logic level, prev, rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_LEN-1:0], pin_raw};
    end

    assign level = chain[SYNC_LEN-1];
    assign prev  = chain[SYNC_LEN];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;

    always_comb begin
        unique case (edge_sel)
            EDGE_RISE: hit = arm & rise;
            EDGE_FALL: hit = arm & fall;
            default:   hit = arm & (rise | fall);
        endcase
    end
endmodule

// File: rtl/tpe_mode_fsm.sv
module tpe_mode_fsm
    import tpe_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tpe_ctrl_t         ctrl,
    input  logic [TIME_W-1:0] match_cfg,
    input  logic [TIME_W-1:0] step_cfg,
    input  logic [TIME_W-1:0] time_now,
    output tpe_state_e        state,
    output logic              pin_out
);
    tpe_state_e        state_nx;
    logic [TIME_W-1:0] next_match;
    logic              due;

    assign due = (time_now >= next_match);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ctrl.en) state_nx = ctrl.dir_in ? ST_LISTEN : ST_ARMED;
            end
            ST_ARMED: begin
                if (!ctrl.en)                      state_nx = ST_IDLE;
                else if (due && !ctrl.repeat_on)   state_nx = ST_SPENT;
            end
            ST_SPENT: begin
                if (!ctrl.en) state_nx = ST_IDLE;
            end
            ST_LISTEN: begin
                if (!ctrl.en) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_match <= '0;
            pin_out    <= 1'b0;
        end else begin
            if (state == ST_IDLE) begin
                next_match <= match_cfg;
            end else if (state == ST_ARMED && ctrl.en && due) begin
                pin_out <= ~pin_out;
                if (ctrl.repeat_on) next_match <= next_match + step_cfg;
            end
        end
    end
endmodule

// File: rtl/tpe_capture.sv
module tpe_capture #(
    parameter int TIME_W = 64,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [TIME_W-1:0] time_now,
    output logic [TIME_W-1:0] stamp,
    output logic [CNT_W-1:0]  tally,
    output logic [CNT_W-1:0]  tally_kept
);
    logic [CNT_W-1:0] tally_inc;

    assign tally_inc = tally + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stamp      <= '0;
            tally      <= '0;
            tally_kept <= '0;
        end else if (hit) begin
            stamp      <= time_now;
            tally      <= tally_inc;
            tally_kept <= tally_inc;
        end
    end
endmodule

// File: rtl/timed_pin_engine.sv
module timed_pin_engine
    import tpe_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int SYNC_LEN = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*DATA_W-1:0] time_now,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                pin_in,
    output logic                pin_out
);
    localparam int TIME_W = 2 * DATA_W;
    localparam int CNT_W  = 2 * DATA_W;

    tpe_ctrl_t         ctrl_q;
    logic [TIME_W-1:0] match_cfg;
    logic [TIME_W-1:0] step_cfg;
    logic [DATA_W-1:0] hi_hold;
    logic [TIME_W-1:0] stamp;
    logic [CNT_W-1:0]  tally;
    logic [CNT_W-1:0]  tally_kept;
    tpe_state_e        state;
    logic              edge_hit;
    logic              cfg_en;
    logic [7:0]        ofs;

    assign cfg_en = ctrl_q.en;
    assign ofs    = 8'(reg_addr);

    // register writes; 64-bit settings are locked while enabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            match_cfg <= '0;
            step_cfg  <= '0;
        end else if (reg_wr) begin
            unique case (ofs)
                OFS_CFG:      ctrl_q <= tpe_ctrl_t'(reg_wdata[CTRL_W-1:0]);
                OFS_MATCH_LO: if (!ctrl_q.en) match_cfg[DATA_W-1:0]      <= reg_wdata;
                OFS_MATCH_HI: if (!ctrl_q.en) match_cfg[TIME_W-1:DATA_W] <= reg_wdata;
                OFS_STEP_LO:  if (!ctrl_q.en) step_cfg[DATA_W-1:0]       <= reg_wdata;
                OFS_STEP_HI:  if (!ctrl_q.en) step_cfg[TIME_W-1:DATA_W]  <= reg_wdata;
                default: ;
            endcase
        end
    end

    // registered reads; low-word reads of live values park the high word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            hi_hold   <= '0;
        end else if (reg_rd) begin
            unique case (ofs)
                OFS_CLOCK_LO: begin
                    reg_rdata <= time_now[DATA_W-1:0];
                    hi_hold   <= time_now[TIME_W-1:DATA_W];
                end
                OFS_STAMP_LO: begin
                    reg_rdata <= stamp[DATA_W-1:0];
                    hi_hold   <= stamp[TIME_W-1:DATA_W];
                end
                OFS_KEPT_LO: begin
                    reg_rdata <= tally_kept[DATA_W-1:0];
                    hi_hold   <= tally_kept[CNT_W-1:DATA_W];
                end
                OFS_TALLY_LO: begin
                    reg_rdata <= tally[DATA_W-1:0];
                    hi_hold   <= tally[CNT_W-1:DATA_W];
                end
                OFS_CLOCK_HI, OFS_STAMP_HI, OFS_KEPT_HI, OFS_TALLY_HI:
                    reg_rdata <= hi_hold;
                OFS_CFG:      reg_rdata <= DATA_W'(ctrl_q);
                OFS_MATCH_LO: reg_rdata <= match_cfg[DATA_W-1:0];
                OFS_MATCH_HI: reg_rdata <= match_cfg[TIME_W-1:DATA_W];
                OFS_STEP_LO:  reg_rdata <= step_cfg[DATA_W-1:0];
                OFS_STEP_HI:  reg_rdata <= step_cfg[TIME_W-1:DATA_W];
                default:      reg_rdata <= '0;
            endcase
        end
    end

    tpe_mode_fsm #(.TIME_W(TIME_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl_q),
        .match_cfg (match_cfg),
        .step_cfg  (step_cfg),
        .time_now  (time_now),
        .state     (state),
        .pin_out   (pin_out)
    );

    tpe_edge_sense #(.SYNC_LEN(SYNC_LEN)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .arm      (state == ST_LISTEN),
        .edge_sel (ctrl_q.edge_sel),
        .hit      (edge_hit)
    );

    tpe_capture #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (edge_hit),
        .time_now   (time_now),
        .stamp      (stamp),
        .tally      (tally),
        .tally_kept (tally_kept)
    );
endmodule

// File: rtl/tpe_checker.sv
module tpe_checker
    import tpe_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pin_out,
    input tpe_state_e        state,
    input logic              en,
    input logic [TIME_W-1:0] match_cfg,
    input logic [TIME_W-1:0] tally,
    input logic              edge_hit,
    input logic [TIME_W-1:0] time_now,
    input logic [TIME_W-1:0] stamp
);
    // R6: only the armed state may move the pin
    p_pin_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ARMED) |=> $stable(pin_out));

    // R4: a spent one-shot stays spent while enabled
    p_spent_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPENT && en) |=> (state == ST_SPENT));

    // R3: programmed match is frozen while enabled
    p_match_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(match_cfg));

    // R10: tally moves by at most one per clock
    p_tally_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tally == $past(tally) || tally == $past(tally) + 1'b1));

    // R10: stamp holds the time of the qualifying clock
    p_stamp_time_r10: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (stamp == $past(time_now)));

    // R11: no qualifying edge, no tally change
    p_tally_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_hit |=> $stable(tally));
endmodule

bind timed_pin_engine tpe_checker #(.TIME_W(64)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_out   (pin_out),
    .state     (state),
    .en        (cfg_en),
    .match_cfg (match_cfg),
    .tally     (tally),
    .edge_hit  (edge_hit),
    .time_now  (time_now),
    .stamp     (stamp)
);

// File: tb/sim_timed_pin_engine.sv
module sim_timed_pin_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pin_in = 1'b0;
    logic        pin_out;

    int n_run = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // model state
    logic [63:0] m_tally = '0;
    logic [63:0] m_stamp = '0;
    logic [63:0] m_kept  = '0;
    logic        m_pin_prev = 1'b0;

    always #2.5 clk = ~clk;

    timed_pin_engine u0 (
        .clk(clk), .rst_n(rst_n), .time_now(time_now),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic rd64(input logic [7:0] a, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(a, lo);
        rd(a + 8'h04, hi);
        d = {hi, lo};
    endtask

    task automatic wr64(input logic [7:0] a, input logic [63:0] d);
        wr(a, d[31:0]);
        wr(a + 8'h04, d[63:32]);
    endtask

    function automatic bit qualifies(input logic [1:0] sel, input logic p, input logic c);
        case (sel)
            2'b00:   return (!p && c);
            2'b01:   return (p && !c);
            default: return (p != c);
        endcase
    endfunction

    // change the pin with the time held at t; listening tells the model to count
    task automatic drive_pin(input logic v, input logic [63:0] t,
                             input logic [1:0] sel, input bit listening);
        @(negedge clk);
        if (listening && qualifies(sel, m_pin_prev, v)) begin
            m_tally = m_tally + 1;
            m_kept  = m_tally;
            m_stamp = t;
        end
        m_pin_prev = v;
        pin_in   = v;
        time_now = t;
        idle(3);
    endtask

    task automatic check_inputs(input string req);
        logic [63:0] v;
        rd64(8'h40, v); chk({req, " tally"}, v, m_tally);
        rd64(8'h30, v); chk({req, " stamp"}, v, m_stamp);
        rd64(8'h38, v); chk({req, " kept"},  v, m_kept);
    endtask

    initial begin : watchdog
        #900000;
        if (!finished) begin
            n_run++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [63:0] v, nxt, stepv, base;
        logic        exp_pin;
        void'($urandom(32'd2024));

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk("R1 pin_out", {63'b0, pin_out}, 64'd0);
        rd(8'h10, d);  chk("R1 ctrl", {32'b0, d}, 64'd0);
        rd64(8'h20, v); chk("R1 match", v, 64'd0);
        rd64(8'h28, v); chk("R1 step", v, 64'd0);
        check_inputs("R1");

        // R2 control layout, upper bits dropped
        wr(8'h10, 32'h0000_001C);
        rd(8'h10, d); chk("R2 ctrl readback", {32'b0, d}, 64'h1C);
        wr(8'h10, 32'hFFFF_FFE0);
        rd(8'h10, d); chk("R2 upper bits dropped", {32'b0, d}, 64'h0);

        // R12 time snapshot
        time_now = 64'h0000_0005_FFFF_FFF0;
        rd(8'h00, d); chk("R12 time low", {32'b0, d}, 64'hFFFF_FFF0);
        time_now = 64'h0000_0006_0000_0001;
        rd(8'h04, d); chk("R12 time high held", {32'b0, d}, 64'h5);

        // R4 one-shot output
        time_now = 64'd990;
        wr64(8'h20, 64'd1000);
        wr(8'h10, 32'h01);
        idle(5);
        chk("R4 before match", {63'b0, pin_out}, 64'd0);
        time_now = 64'd1000; idle(3);
        chk("R4 toggle at match", {63'b0, pin_out}, 64'd1);
        time_now = 64'd5000; idle(5);
        chk("R4 holds after one shot", {63'b0, pin_out}, 64'd1);

        // R3 writes while enabled are ignored
        wr(8'h20, 32'hDEAD_BEEF);
        wr(8'h2C, 32'h1234_5678);
        rd64(8'h20, v); chk("R3 match locked", v, 64'd1000);
        rd64(8'h28, v); chk("R3 step locked", v, 64'd0);

        // R5 repeat mode with random step
        exp_pin = 1'b1;
        wr(8'h10, 32'h10);
        stepv = 64'($urandom_range(40, 1));
        base  = 64'd3000 + 64'($urandom_range(500, 0));
        wr64(8'h28, stepv);
        wr64(8'h20, base);
        rd64(8'h20, v); chk("R3 match writable when disabled", v, base);
        time_now = base - 1;
        wr(8'h10, 32'h11);
        idle(4);
        chk("R5 no toggle before first match", {63'b0, pin_out}, {63'b0, exp_pin});
        nxt = base;
        for (int k = 0; k < 10; k++) begin
            time_now = nxt - 1; idle(3);
            chk("R5 quiet below match", {63'b0, pin_out}, {63'b0, exp_pin});
            time_now = nxt; idle(3);
            exp_pin = ~exp_pin;
            nxt = nxt + stepv;
            chk("R5 periodic toggle", {63'b0, pin_out}, {63'b0, exp_pin});
        end
        // catch-up: two whole steps past the next match gives three toggles
        time_now = nxt + 2 * stepv; idle(8);
        exp_pin = ~exp_pin;
        nxt = nxt + 3 * stepv;
        chk("R5 catch-up parity", {63'b0, pin_out}, {63'b0, exp_pin});
        time_now = nxt - 1; idle(4);
        chk("R5 settled after catch-up", {63'b0, pin_out}, {63'b0, exp_pin});

        // R6 disabled pin never moves, re-enable re-arms
        wr(8'h10, 32'h10);
        time_now = nxt + 64'd100000; idle(6);
        chk("R6 still while disabled", {63'b0, pin_out}, {63'b0, exp_pin});
        wr64(8'h20, time_now + 64'd50);
        wr(8'h10, 32'h01);
        idle(6);
        chk("R6 rearm waits for new match", {63'b0, pin_out}, {63'b0, exp_pin});
        time_now = time_now + 64'd50; idle(3);
        exp_pin = ~exp_pin;
        chk("R6 rearm fires", {63'b0, pin_out}, {63'b0, exp_pin});

        // R11 output mode ignores input edges
        drive_pin(1'b1, 64'd7000, 2'b10, 1'b0);
        drive_pin(1'b0, 64'd7001, 2'b10, 1'b0);
        check_inputs("R11 output mode");

        // R11 disabled ignores edges; high pin at enable is not an edge
        wr(8'h10, 32'h0);
        drive_pin(1'b1, 64'd7100, 2'b00, 1'b0);
        drive_pin(1'b0, 64'd7101, 2'b00, 1'b0);
        drive_pin(1'b1, 64'd7102, 2'b00, 1'b0);
        wr(8'h10, 32'h03);
        idle(4);
        check_inputs("R11 high at enable");

        // R7 rising, R8 falling, R9 both: directed then random
        for (int s = 0; s < 4; s++) begin
            logic [1:0] sel = 2'(s);
            logic [63:0] t = 64'h0000_0001_0000_0000 * (s + 1);
            wr(8'h10, 32'h0);
            wr(8'h10, {27'b0, 1'b0, sel, 1'b1, 1'b1});
            idle(3);
            drive_pin(~m_pin_prev, t, sel, 1'b1);
            drive_pin(~m_pin_prev, t + 64'd7, sel, 1'b1);
            for (int k = 0; k < 30; k++) begin
                t = t + 64'($urandom_range(300, 1));
                drive_pin(1'($urandom), t, sel, 1'b1);
            end
            case (s)
                0: check_inputs("R7 rising R10");
                1: check_inputs("R8 falling R10");
                default: check_inputs("R9 both R10");
            endcase
        end

        // R12 capture snapshot survives a later edge between the two reads
        wr(8'h10, 32'h0B);
        idle(3);
        drive_pin(~m_pin_prev, 64'h0000_00AA_0000_0010, 2'b10, 1'b1);
        rd(8'h30, d); chk("R12 stamp low", {32'b0, d}, 64'h10);
        drive_pin(~m_pin_prev, 64'h0000_00BB_0000_0020, 2'b10, 1'b1);
        rd(8'h34, d); chk("R12 stamp high held", {32'b0, d}, 64'hAA);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule